// File: doc/BRIEF.md
# Serial-Bus EEPROM Target with Page Buffer

This block is a two-wire serial bus (I2C) target placed in front of a 256-byte non-volatile store. The store is modelled as a register array plus an internal write-cycle timer. A bus controller addresses the block with a 7-bit device address. In that address the upper four bits are the fixed code 1010 and the lower three come from the `strap` pins. In a write transfer the controller then sends an 8-bit word address, followed by one or more data bytes. The data bytes land in a small page buffer, and the buffer is copied into the array only when the controller issues a STOP.

During a page write only the low two bits of the word address advance, so a burst longer than four bytes wraps around inside its 4-byte page and overwrites the bytes sent earlier. After a committing STOP the block stays busy for a fixed number of clocks. While it is busy it refuses its device address. The `wr_lock` input blocks every change to the array. Reads stream bytes out from the current pointer, and that pointer advances across the full address range.

SCL and SDA are oversampled by the system clock, so each bus phase must last several clock periods. `sda_oe` is the open-drain pull-down request for the SDA line.

Top module: `ee_i2c_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal the fixed code 1010 followed by `strap[2:0]` (bit 0 is R/W, where 1 means read). Any other address gets no acknowledge, and the block stays silent until the next START.
- R2: In a write transfer, the first byte after the address loads the word pointer. The block acknowledges the address byte, the word-address byte and every data byte.
- R3: A single data byte followed by STOP is written to the array at the word address. It can be read back once the busy period has ended.
- R4: Each data byte of a write burst advances only pointer bits [1:0]. Bits [7:2] keep their value, so a burst longer than four bytes wraps around inside the page and the later bytes overwrite the earlier ones.
- R5: Buffered bytes reach the array only on STOP. A repeated START before STOP discards them, leaves the array unchanged and starts no busy period.
- R6: While `wr_lock` is 1, data bytes are still acknowledged but the array does not change and no busy period begins.
- R7: After a committing STOP the block is busy for PAGE_BYTES + WR_CYCLES clocks. During that time its device address is not acknowledged. After that time it is acknowledged again.
- R8: A read returns the byte at the pointer and then increments the full 8-bit pointer, wrapping from 255 to 0. Each controller acknowledge requests one more byte. A controller no-acknowledge ends the read. A later read without a word address continues from the next byte.
- R9: Reset releases SDA and sets the pointer to 0. The array starts out holding all zeros.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or read data 0) |
| strap | input | 3 | Low three bits of the device address |
| wr_lock | input | 1 | 1 blocks every change to the array |

## Verification
After each SCL falling edge the block's drive on SDA settles within three clocks: two synchroniser stages plus the output register. The bench therefore reads the line a quarter bit period after the following rising edge, never near the fall. An array update becomes visible PAGE_BYTES + WR_CYCLES + 1 clocks after STOP is detected. The bench waits a little longer than that before any read-back. It places its busy-period probe so that the address decision, which is made on the eighth falling edge, falls well inside the busy window. Expected data comes from a byte model in the bench that applies the page-wrap arithmetic itself.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_WADR,
    S_WADR_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_RDAT,
    S_RACK
  } bus_st_t;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, scl_d, sda_m, sda_s, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE_BYTES = 4,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [PW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [PW-1:0] ridx,
  output logic [7:0]    rdata,
  output logic          rvalid,
  output logic          any_valid
);
  logic [PAGE_BYTES-1:0] vld;
  logic [7:0]            slot [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        vld[g] <= 1'b0;
      end else if (wr && widx == PW'(g)) begin
        vld[g] <= 1'b1;
      end
      if (wr && widx == PW'(g)) slot[g] <= wdata;  // R4 later byte overwrites
    end
  end

  assign rdata     = slot[ridx];
  assign rvalid    = vld[ridx];
  assign any_valid = |vld;
endmodule

// File: rtl/ee_commit.sv
module ee_commit #(
  parameter int PAGE_BYTES = 4,
  parameter int WR_CYCLES  = 64,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int TW = $clog2(WR_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          busy,
  output logic          copying,
  output logic [PW-1:0] idx,
  output logic          done
);
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      copying <= 1'b0;
      idx     <= '0;
      tmr     <= '0;
    end else if (go) begin
      copying <= 1'b1;
      idx     <= '0;
    end else if (copying) begin
      idx <= idx + 1'b1;
      if (idx == PW'(PAGE_BYTES - 1)) begin
        copying <= 1'b0;
        tmr     <= TW'(WR_CYCLES);
      end
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  assign busy = copying | (tmr != '0);
  assign done = copying && (idx == PW'(PAGE_BYTES - 1));
endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;  // R9 blank array
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee_i2c_target.sv
module ee_i2c_target
  import ee_pkg::*;
#(
  parameter int         MEM_BYTES  = 256,
  parameter int         PAGE_BYTES = 4,
  parameter int         WR_CYCLES  = 64,
  parameter logic [3:0] DEV_CODE   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       wr_lock
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HW = AW - PW;

  logic scl_s, scl_rise, scl_fall, start_det, stop_det;
  bus_st_t       st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, tx;
  logic          rw, mack, oe_q;
  logic [AW-1:0] ptr;
  logic [HW-1:0] base_hi;

  logic       buf_wr, buf_clr, buf_rvalid, buf_any;
  logic [7:0] buf_rdata;
  logic       go, cm_busy, cm_copying, cm_done;
  logic [PW-1:0] cm_idx;
  logic       mem_we;
  logic [7:0] mem_rdata;
  logic       dev_hit, byte_end;

  ee_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // R1 device match, refused while a write cycle runs (R7)
  assign dev_hit  = (shreg[7:1] == {DEV_CODE, strap}) && !cm_busy;
  assign byte_end = scl_fall && (bitcnt == 4'd8);
  // R6 locked data bytes are acknowledged but never buffered
  assign buf_wr   = byte_end && (st == S_WDAT) && !wr_lock;
  // R5 commit only on STOP
  assign go       = stop_det && !wr_lock && buf_any && !cm_busy;
  assign buf_clr  = cm_done | ((start_det | (stop_det & ~go)) & ~cm_busy);
  assign mem_we   = cm_copying & buf_rvalid;

  ee_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr(buf_wr),
    .widx(ptr[PW-1:0]), .wdata(shreg), .ridx(cm_idx),
    .rdata(buf_rdata), .rvalid(buf_rvalid), .any_valid(buf_any)
  );

  ee_commit #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_commit (
    .clk(clk), .rst(rst), .go(go), .busy(cm_busy),
    .copying(cm_copying), .idx(cm_idx), .done(cm_done)
  );

  ee_store #(.DEPTH(MEM_BYTES)) u_store (
    .clk(clk), .we(mem_we), .waddr({base_hi, cm_idx}), .wdata(buf_rdata),
    .raddr(ptr), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      oe_q    <= 1'b0;
      ptr     <= '0;
      base_hi <= '0;
    end else if (start_det) begin
      st     <= S_DEV;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else if (stop_det) begin
      st   <= S_IDLE;
      oe_q <= 1'b0;
    end else if (scl_rise) begin
      case (st)
        S_DEV, S_WADR, S_WDAT: begin
          shreg  <= {shreg[6:0], sda_i_s()};
          bitcnt <= bitcnt + 1'b1;
        end
        S_RACK: mack <= ~sda_i_s();
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        S_DEV: if (bitcnt == 4'd8) begin
          if (dev_hit) begin
            oe_q <= 1'b1;
            rw   <= shreg[0];
            st   <= S_DEV_ACK;
          end else begin
            st <= S_IDLE;
          end
        end
        S_DEV_ACK: begin
          if (rw) begin
            st     <= S_RDAT;
            oe_q   <= ~mem_rdata[7];
            tx     <= {mem_rdata[6:0], 1'b0};
            bitcnt <= 4'd1;
          end else begin
            st     <= S_WADR;
            oe_q   <= 1'b0;
            bitcnt <= '0;
          end
        end
        S_WADR: if (bitcnt == 4'd8) begin
          ptr     <= shreg[AW-1:0];         // R2 pointer load
          base_hi <= shreg[AW-1:PW];
          oe_q    <= 1'b1;
          st      <= S_WADR_ACK;
        end
        S_WDAT: if (bitcnt == 4'd8) begin
          ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1; // R4 low bits only
          oe_q        <= 1'b1;
          st          <= S_WDAT_ACK;
        end
        S_WADR_ACK, S_WDAT_ACK: begin
          oe_q   <= 1'b0;
          bitcnt <= '0;
          st     <= S_WDAT;
        end
        S_RDAT: begin
          if (bitcnt == 4'd8) begin
            oe_q <= 1'b0;
            ptr  <= ptr + 1'b1;             // R8 full-width increment
            st   <= S_RACK;
          end else begin
            oe_q   <= ~tx[7];
            tx     <= {tx[6:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
          end
        end
        S_RACK: begin
          if (mack) begin
            st     <= S_RDAT;
            oe_q   <= ~mem_rdata[7];
            tx     <= {mem_rdata[6:0], 1'b0};
            bitcnt <= 4'd1;
          end else begin
            st <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  function automatic logic sda_i_s();
    return u_sync.sda_s;
  endfunction

  assign sda_oe = oe_q;
endmodule

// File: rtl/ee_i2c_target_chk.sv
module ee_i2c_target_chk
  import ee_pkg::*;
#(
  parameter int PAGE_BYTES = 4,
  parameter int WR_CYCLES  = 64,
  localparam int LIM = PAGE_BYTES + WR_CYCLES,
  localparam int RW  = $clog2(LIM + 2),
  localparam int CW  = $clog2(PAGE_BYTES + 2)
) (
  input logic    clk,
  input logic    rst,
  input logic    scl_s,
  input logic    stop_det,
  input logic    wr_lock,
  input logic    busy,
  input logic    mem_we,
  input logic    sda_oe,
  input bus_st_t st
);
  logic [RW-1:0] run;
  logic [CW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) run <= '0;
    else              run <= run + 1'b1;
    if (rst || !busy) wcnt <= '0;
    else if (mem_we)  wcnt <= wcnt + 1'b1;
  end

  p_commit_on_stop_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));
  p_lock_no_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(wr_lock));
  p_busy_nack_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> st != S_DEV_ACK);
  p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> run < RW'(LIM));
  p_page_limit_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wcnt < CW'(PAGE_BYTES));
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);
endmodule

bind ee_i2c_target ee_i2c_target_chk #(
  .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det),
  .wr_lock(wr_lock), .busy(cm_busy), .mem_we(mem_we),
  .sda_oe(sda_oe), .st(st)
);

// File: tb/sim_ee_i2c_target.sv
module sim_ee_i2c_target;
  localparam int CLK_NS = 10;
  localparam int Q      = 4;
  localparam int WRC    = 300;
  localparam int PG     = 4;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, m_sda = 1'b1, lock = 1'b0;
  logic sda_oe, line;
  assign line = m_sda & ~sda_oe;

  ee_i2c_target #(.PAGE_BYTES(PG), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(line), .sda_oe(sda_oe),
    .strap(STRAP), .wr_lock(lock)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, r10_viol = 0;
  bit finished = 1'b0;
  logic [7:0] exp_mem [256];
  logic prev_oe = 1'b0;

  always @(negedge clk) begin
    if (!rst && scl && sda_oe !== prev_oe) r10_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(a);
    ack = (a == 1'b0);
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    send_bit(!give_ack);
  endtask

  task automatic set_ptr_then_read(input logic [7:0] a);
    bit ack;
    bus_start;
    put_byte(DEV_W, ack); chk(ack, "R2 device ack", ack, 1);
    put_byte(a, ack);     chk(ack, "R2 word address ack", ack, 1);
    bus_start;
    put_byte(DEV_R, ack); chk(ack, "R1 read address ack", ack, 1);
  endtask

  task automatic read_check(input logic [7:0] a, input int n, input string req);
    logic [7:0] v;
    set_ptr_then_read(a);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, v);
      chk(v == exp_mem[8'(a + i)], req, v, exp_mem[8'(a + i)]);
    end
    bus_stop;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    tick(6); rst = 1'b0; tick(4);

    // R9 reset state: line released, pointer at 0, blank array
    chk(sda_oe == 1'b0, "R9 sda released after reset", sda_oe, 0);
    bus_start;
    put_byte(DEV_R, ack); chk(ack, "R9 read address ack", ack, 1);
    get_byte(1'b0, v);    chk(v == 8'h00, "R9 byte at pointer 0", v, 0);
    bus_stop;

    // R1 sweep of code and strap bits
    for (int c = 0; c < 16; c++) begin
      bus_start; put_byte({4'(c), STRAP, 1'b0}, ack);
      chk(ack == (c == 10), "R1 code sweep", ack, c == 10);
      bus_stop;
    end
    for (int s = 0; s < 8; s++) begin
      bus_start; put_byte({4'b1010, 3'(s), 1'b0}, ack);
      chk(ack == (3'(s) == STRAP), "R1 strap sweep", ack, 3'(s) == STRAP);
      bus_stop;
    end

    // R4 fill the whole array through page writes
    for (int p = 0; p < 64; p++) begin
      bus_start;
      put_byte(DEV_W, ack);     chk(ack, "R2 device ack", ack, 1);
      put_byte(8'(p * 4), ack); chk(ack, "R2 word address ack", ack, 1);
      for (int k = 0; k < 4; k++) begin
        put_byte(8'((p * 4 + k) * 37 + 11), ack);
        chk(ack, "R2 data ack", ack, 1);
        exp_mem[p * 4 + k] = 8'((p * 4 + k) * 37 + 11);
      end
      bus_stop;
      tick(PG + WRC + 8);
    end
    // R8 stream 257 bytes, crossing 255 -> 0
    read_check(8'h00, 257, "R8 sequential read with wrap");

    // R3 byte write, R7 busy refusal then recovery
    bus_start;
    put_byte(DEV_W, ack); put_byte(8'h5D, ack); put_byte(8'hC3, ack);
    chk(ack, "R3 data ack", ack, 1);
    bus_stop;
    exp_mem[8'h5D] = 8'hC3;
    bus_start; put_byte(DEV_W, ack);
    chk(!ack, "R7 address refused while busy", ack, 0);
    bus_stop;
    tick(PG + WRC + 8);
    bus_start; put_byte(DEV_W, ack);
    chk(ack, "R7 address accepted after busy", ack, 1);
    bus_stop;
    read_check(8'h5D, 1, "R3 byte write read-back");

    // R4 six bytes from offset 2 wrap inside the page
    bus_start;
    put_byte(DEV_W, ack); put_byte(8'h42, ack);
    for (int k = 0; k < 6; k++) begin
      put_byte(8'(8'h90 + k), ack);
      chk(ack, "R4 burst data ack", ack, 1);
      exp_mem[{6'h10, 2'(2 + k)}] = 8'(8'h90 + k);
    end
    bus_stop;
    tick(PG + WRC + 8);
    read_check(8'h40, 8, "R4 page wrap contents");

    // R6 locked writes
    lock = 1'b1;
    bus_start;
    put_byte(DEV_W, ack); put_byte(8'h80, ack);
    for (int k = 0; k < 3; k++) begin
      put_byte(8'(8'h3C + k), ack);
      chk(ack, "R6 locked data still acked", ack, 1);
    end
    bus_stop;
    bus_start; put_byte(DEV_W, ack);
    chk(ack, "R6 no busy period after locked write", ack, 1);
    bus_stop;
    lock = 1'b0;
    read_check(8'h80, 3, "R6 array unchanged");

    // R5 repeated START discards buffered bytes
    bus_start;
    put_byte(DEV_W, ack); put_byte(8'h10, ack);
    put_byte(8'hAA, ack); put_byte(8'hBB, ack);
    bus_start;
    put_byte(DEV_R, ack); chk(ack, "R5 read after repeated start", ack, 1);
    get_byte(1'b0, v);
    chk(v == exp_mem[8'h12], "R5 byte at advanced pointer", v, exp_mem[8'h12]);
    bus_stop;
    bus_start; put_byte(DEV_W, ack);
    chk(ack, "R5 no busy period after abort", ack, 1);
    bus_stop;
    read_check(8'h10, 2, "R5 aborted bytes not committed");

    // R8 pointer continues after a finished read
    read_check(8'hFE, 2, "R8 read at top of range");
    bus_start;
    put_byte(DEV_R, ack); chk(ack, "R8 current-address read ack", ack, 1);
    get_byte(1'b0, v);
    chk(v == exp_mem[8'h00], "R8 pointer wrapped to 0", v, exp_mem[8'h00]);
    bus_stop;

    chk(r10_viol == 0, "R10 sda_oe steady while SCL high", r10_viol, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule